// File: doc/BRIEF.md
# Reference-Switch Phase Aligner

This block sits between a reference selector and a digital phase-locked loop. It accepts two independent reference pulse streams, forwards the selected one, and also takes the loop's feedback pulse stream. Each time the selection changes, it measures how many master-clock cycles pass from the first rising edge of the newly chosen reference to the next rising edge of the feedback. That count becomes a persistent delay, applied to every later edge of the new reference. The loop downstream therefore sees a virtual reference that stays in phase with its own feedback, and the switchover causes no phase step.

The measurement counter wraps at the feedback period. That period comes from a two-bit rate code matched to the reference frequency. A mode controller gates the correction through an enable input. A clear input returns the stored delay to zero, after which the virtual reference equals the raw reference. The rate code must only change while the block is held in reset.

Top module: `refswitch_phase_aligner`

## Requirements
- R1: After reset, `vref_out` is low and the stored offset is zero, so a rising edge on the selected reference shows on `vref_out` one cycle later.
- R2: `ref_pick` = 0 routes `ref_a` and `ref_pick` = 1 routes `ref_b`. Edges on the reference that is not routed produce no `vref_out` pulse.
- R3: Each rising edge of the routed reference produces exactly one `vref_out` pulse, one cycle wide. The pulse rises (offset + 1) cycles after the edge is sampled.
- R4: When `ref_pick` changes while `corr_en` is high, the block waits for the next rising edge of the routed reference. It then counts cycles to the next rising edge of `fb_pulse` and stores the count as the new offset. Later, `vref_out` rises in the same cycle position as it would for a feedback-aligned reference.
- R5: The measured count wraps modulo the feedback period chosen by `fb_rate`: 01 selects P_LOW cycles (default 2048), 10 selects P_MID (default 11), 11 selects P_HIGH (default 8). The stored offset is therefore always smaller than that period.
- R6: If the feedback edge arrives in the same cycle as the measured reference edge, the stored offset is zero.
- R7: While `corr_en` is low, the offset is frozen. A selection change starts no measurement, and dropping `corr_en` during a measurement abandons it.
- R8: `offset_clr` high sets the offset to zero and abandons any measurement in progress. It takes priority over every other input.
- R9: `fb_rate` = 00 is reserved. A selection change under that code starts no measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_a | input | 1 | First reference pulse stream |
| ref_b | input | 1 | Second reference pulse stream |
| ref_pick | input | 1 | Reference select (0 = ref_a, 1 = ref_b) |
| fb_pulse | input | 1 | Feedback pulse stream from the PLL |
| corr_en | input | 1 | Correction enable from the mode controller |
| offset_clr | input | 1 | Clears the stored offset |
| fb_rate | input | 2 | Feedback rate code |
| vref_out | output | 1 | Virtual reference pulse stream |

## Verification
Switchovers are run with feedback gaps of zero, a few cycles, and more than one period at each of the three rates. This separates a plain count from a wrapped one and covers the coincident-edge case. Each measurement is followed by a probe pulse whose lag shows the stored offset at the output. Other switchovers are interrupted by a dropped enable or a clear, or made under the reserved rate. A probe lag that does not change tells an ignored measurement apart from one that was captured. A pulse on the unrouted reference must give no output at all.

// File: rtl/phalign_pkg.sv
package phalign_pkg;

  typedef enum logic [1:0] {
    RATE_RSVD = 2'b00,
    RATE_LOW  = 2'b01,
    RATE_MID  = 2'b10,
    RATE_HIGH = 2'b11
  } fb_rate_e;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_WAIT_REF,
    MS_COUNT
  } meas_state_e;

  // Feedback period in master-clock cycles for a rate code; 0 for reserved.
  function automatic int unsigned period_for(input logic [1:0] rate,
                                             input int unsigned p_low,
                                             input int unsigned p_mid,
                                             input int unsigned p_high);
    case (rate)
      RATE_LOW:  return p_low;
      RATE_MID:  return p_mid;
      RATE_HIGH: return p_high;
      default:   return 0;
    endcase
  endfunction

  // Next value of a counter that wraps to zero at the given period.
  function automatic int unsigned wrap_inc(input int unsigned cnt,
                                           input int unsigned period);
    return (cnt + 1 >= period) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/phalign_rise.sv
module phalign_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/phalign_meter.sv
module phalign_meter
  import phalign_pkg::*;
#(
  parameter int unsigned CW     = 12,
  parameter int unsigned P_LOW  = 2048,
  parameter int unsigned P_MID  = 11,
  parameter int unsigned P_HIGH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [1:0]    rate,
  input  logic          switch_evt,
  input  logic          ref_edge,
  input  logic          fb_edge,
  output logic [CW-1:0] delay_q,
  output logic          capture_evt
);
  meas_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, dly_d;
  int unsigned   period;

  always_comb begin
    period      = period_for(rate, P_LOW, P_MID, P_HIGH);
    state_d     = state_q;
    cnt_d       = cnt_q;
    dly_d       = delay_q;
    capture_evt = 1'b0;
    if (clr) begin
      state_d = MS_IDLE;
      dly_d   = '0;
    end else if (!en) begin
      state_d = MS_IDLE;
    end else if (switch_evt) begin
      state_d = (rate == RATE_RSVD) ? MS_IDLE : MS_WAIT_REF;
    end else begin
      case (state_q)
        MS_WAIT_REF: if (ref_edge) begin
          if (fb_edge) begin
            dly_d       = '0;
            capture_evt = 1'b1;
            state_d     = MS_IDLE;
          end else begin
            cnt_d   = CW'(wrap_inc(0, period));
            state_d = MS_COUNT;
          end
        end
        MS_COUNT: if (fb_edge) begin
          dly_d       = cnt_q;
          capture_evt = 1'b1;
          state_d     = MS_IDLE;
        end else begin
          cnt_d = CW'(wrap_inc(32'(cnt_q), period));
        end
        default: state_d = MS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      delay_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      delay_q <= dly_d;
    end
  end
endmodule

// File: rtl/phalign_delay_line.sv
module phalign_delay_line #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_edge,
  input  logic [CW-1:0] delay,
  output logic          vref_q
);
  logic          active_q;
  logic [CW-1:0] left_q;
  logic          fire;

  assign fire = (ref_edge && delay == '0) || (active_q && left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
      vref_q   <= 1'b0;
    end else begin
      vref_q <= fire;
      if (ref_edge && delay != '0) begin
        active_q <= 1'b1;
        left_q   <= delay - CW'(1);
      end else if (active_q) begin
        if (left_q == '0) active_q <= 1'b0;
        else              left_q   <= left_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/refswitch_phase_aligner.sv
module refswitch_phase_aligner #(
  parameter int unsigned P_LOW  = 2048,
  parameter int unsigned P_MID  = 11,
  parameter int unsigned P_HIGH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_a,
  input  logic       ref_b,
  input  logic       ref_pick,
  input  logic       fb_pulse,
  input  logic       corr_en,
  input  logic       offset_clr,
  input  logic [1:0] fb_rate,
  output logic       vref_out
);
  localparam int unsigned CW   = $clog2(P_LOW) + 1;
  localparam int unsigned NSIG = 3;
  localparam int unsigned IDX_FB = 2;

  logic [NSIG-1:0] raw_sig, rise_sig;
  logic            pick_q;
  logic            switch_evt;
  logic            ref_edge;
  logic            fb_edge;
  logic            capture_evt;
  logic [CW-1:0]   delay_q;

  assign raw_sig = {fb_pulse, ref_b, ref_a};

  for (genvar g = 0; g < NSIG; g++) begin : g_rise
    phalign_rise u_rise (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (raw_sig[g]),
      .rise (rise_sig[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pick_q <= 1'b0;
    else        pick_q <= ref_pick;
  end

  assign switch_evt = ref_pick ^ pick_q;
  assign ref_edge   = ref_pick ? rise_sig[1] : rise_sig[0];
  assign fb_edge    = rise_sig[IDX_FB];

  phalign_meter #(
    .CW(CW), .P_LOW(P_LOW), .P_MID(P_MID), .P_HIGH(P_HIGH)
  ) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (corr_en),
    .clr        (offset_clr),
    .rate       (fb_rate),
    .switch_evt (switch_evt),
    .ref_edge   (ref_edge),
    .fb_edge    (fb_edge),
    .delay_q    (delay_q),
    .capture_evt(capture_evt)
  );

  phalign_delay_line #(.CW(CW)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_edge(ref_edge),
    .delay   (delay_q),
    .vref_q  (vref_out)
  );
endmodule

// File: rtl/phalign_chk.sv
module phalign_chk
  import phalign_pkg::*;
#(
  parameter int unsigned CW     = 12,
  parameter int unsigned P_LOW  = 2048,
  parameter int unsigned P_MID  = 11,
  parameter int unsigned P_HIGH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vref_out,
  input logic          corr_en,
  input logic          offset_clr,
  input logic [1:0]    fb_rate,
  input logic          ref_edge,
  input logic          fb_edge,
  input logic          capture_evt,
  input logic [CW-1:0] delay_q
);
  // R3
  zero_offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && delay_q == '0) |=> vref_out);

  // R4
  capture_on_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> fb_edge);

  // R5
  offset_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (32'(delay_q) < period_for($past(fb_rate), P_LOW, P_MID, P_HIGH)));

  // R7
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!corr_en && !offset_clr) |=> $stable(delay_q));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset_clr |=> (delay_q == '0));
endmodule

bind refswitch_phase_aligner phalign_chk #(
  .CW(CW), .P_LOW(P_LOW), .P_MID(P_MID), .P_HIGH(P_HIGH)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .vref_out   (vref_out),
  .corr_en    (corr_en),
  .offset_clr (offset_clr),
  .fb_rate    (fb_rate),
  .ref_edge   (ref_edge),
  .fb_edge    (fb_edge),
  .capture_evt(capture_evt),
  .delay_q    (delay_q)
);

// File: tb/refswitch_phase_aligner_tb_top.sv
module refswitch_phase_aligner_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_a = 1'b0, ref_b = 1'b0, ref_pick = 1'b0, fb_pulse = 1'b0;
  logic       corr_en = 1'b1, offset_clr = 1'b0;
  logic [1:0] fb_rate = 2'b11;
  logic       vref_out;
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;

  refswitch_phase_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .ref_pick(ref_pick),
    .fb_pulse(fb_pulse), .corr_en(corr_en), .offset_clr(offset_clr),
    .fb_rate(fb_rate), .vref_out(vref_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ref(input logic v);
    if (ref_pick) ref_b = v;
    else          ref_a = v;
  endtask

  task automatic do_reset(input logic [1:0] rate);
    rst_n = 1'b0; fb_rate = rate; ref_a = 0; ref_b = 0; ref_pick = 0;
    fb_pulse = 0; corr_en = 1; offset_clr = 0;
    repeat (3) @(negedge clk);
    check("R1 vref low in reset", int'(vref_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Pulse the routed reference; expect lag = offset + 1 and a one-cycle pulse.
  task automatic probe(input string req, input int exp_lag);
    int lag = -1;
    set_ref(1'b1);
    @(negedge clk);
    set_ref(1'b0);
    for (int k = 1; k <= 3000; k++) begin
      if (vref_out) begin lag = k; break; end
      @(negedge clk);
    end
    check(req, lag, exp_lag);
    @(negedge clk);
    check("R3 pulse one cycle wide", int'(vref_out), 0);
    repeat (10) @(negedge clk);
  endtask

  // Switch reference, pulse it, then feedback m cycles later.
  // intr: 0 none, 1 drop enable mid-measurement, 2 pulse clear mid-measurement.
  task automatic measure(input int m, input int intr);
    ref_pick = ~ref_pick;
    repeat (3) @(negedge clk);
    set_ref(1'b1);
    if (m == 0) fb_pulse = 1'b1;
    @(negedge clk);
    set_ref(1'b0);
    fb_pulse = 1'b0;
    if (m > 0) begin
      for (int j = 1; j < m; j++) begin
        if (j == 1 && intr == 1) corr_en = 1'b0;
        if (j == 1 && intr == 2) offset_clr = 1'b1;
        if (j == 2 && intr != 0) begin corr_en = 1'b1; offset_clr = 1'b0; end
        @(negedge clk);
      end
      fb_pulse = 1'b1;
      @(negedge clk);
      fb_pulse = 1'b0;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset_state;
    do_reset(2'b11);
    probe("R1 zero offset after reset", 1);
  endtask

  task automatic t_unrouted;
    int seen = 0;
    ref_b = 1'b1;
    @(negedge clk);
    ref_b = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (vref_out) seen++;
      @(negedge clk);
    end
    check("R2 unrouted reference ignored", seen, 0);
  endtask

  task automatic t_basic_measure;
    measure(3, 0); probe("R4 offset 3 via ref_b", 4);
    measure(0, 0); probe("R6 coincident edges give zero", 1);
    measure(10, 0); probe("R5 wrap at period 8", 3);
  endtask

  task automatic t_enable;
    corr_en = 1'b0;
    measure(5, 0);
    corr_en = 1'b1;
    probe("R7 no capture while disabled", 3);
    measure(5, 1); probe("R7 disable aborts measurement", 3);
  endtask

  task automatic t_clear;
    measure(4, 0); probe("R4 offset 4", 5);
    offset_clr = 1'b1;
    @(negedge clk);
    offset_clr = 1'b0;
    repeat (2) @(negedge clk);
    probe("R8 clear zeroes offset", 1);
    measure(6, 0); probe("R4 offset 6", 7);
    measure(4, 2); probe("R8 clear aborts measurement", 1);
  endtask

  task automatic t_rates;
    do_reset(2'b10);
    measure(13, 0); probe("R5 wrap at period 11", 3);
    measure(6, 0);  probe("R4 offset 6 at mid rate", 7);
    do_reset(2'b01);
    measure(2050, 0); probe("R5 wrap at period 2048", 3);
    measure(5, 0);    probe("R4 offset 5 at low rate", 6);
  endtask

  task automatic t_reserved;
    do_reset(2'b00);
    measure(4, 0); probe("R9 reserved rate takes no measurement", 1);
  endtask

  initial begin
    t_reset_state();
    t_unrouted();
    t_basic_measure();
    t_enable();
    t_clear();
    t_rates();
    t_reserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule